// File: doc/BRIEF.md
# Time-of-day update and alarm engine

This block keeps a calendar clock made of seconds, minutes, hours, day of week, day of month, month and two-digit year. Each accepted one-second tick advances the internal counters at once. The block then runs an update window of `UPD_CYCLES` clock cycles. During that window the update-in-progress indication is high. When the window closes, the visible time bytes are refreshed, the alarm is evaluated and the update-ended pulse is produced. The visible bytes are encoded in BCD or binary and in 12-hour or 24-hour form, as the format inputs select at that moment.

The host side keeps the register file and drives this block with the oscillator select field, the format, set-mode and enable bits, the three alarm bytes and a load strobe with seven time bytes. On the load strobe the block decodes those bytes with the current format into its counters. The raw bytes become visible at once. While set mode is active, the counters keep running but the visible bytes stay frozen. Flags leave the block as one-cycle pulses, and the sticky status register that collects them sits outside.

Top module: `rtc_tod_engine`

## Requirements
- R1: After reset the visible bytes read second 0x00, minute 0x00, hour 0x00, day-of-week 0x01, date 0x01, month 0x01 and year 0x00. `uip_o`, `alarm_o` and `upd_done_o` are low.
- R2: Each accepted tick adds one second. Seconds carry into minutes at 59, minutes carry into hours at 59 and hours wrap at 23. Each hour wrap moves the day of week on by one, and day of week 7 wraps to 1.
- R3: The date wraps to 1 after the last day of the month and carries into the month. April, June, September and November end on day 30. February ends on day 29 when the year is divisible by 4, and on day 28 otherwise. All other months end on day 31. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.
- R4: With `bin_mode_i` high, every byte holds its plain binary value. With it low, every byte holds two BCD digits, with the tens digit in bits 7:4.
- R5: With `h24_i` low, the hour byte holds 1 to 12 in bits 6:0, and bit 7 is set for PM. Hour 0 is shown as 12 AM and hour 12 as 12 PM. 11 AM advances to 12 PM, 12 PM advances to 1 PM, and 11 PM advances to 12 AM of the next day.
- R6: A tick is accepted only when `osc_sel_i` equals 3'b010. With any other value the tick changes no counter, raises no `uip_o` and produces no pulse.
- R7: Outside set mode, `uip_o` rises in the cycle after an accepted tick. It stays high for exactly `UPD_CYCLES` cycles and falls in the cycle in which the visible bytes are refreshed.
- R8: While `set_mode_i` is high, `uip_o` is low and the visible bytes do not change except by a load. The counters keep advancing, so the first update after set mode ends shows every tick that was accepted during set mode.
- R9: At the end of an update, `alarm_o` pulses for one cycle when `alarm_en_i` is high and each of the seconds, minutes and hours alarm bytes either equals the new encoded byte or has bits 7:6 equal to 2'b11.
- R10: At the end of every accepted update, `upd_done_o` pulses for one cycle when `upd_en_i` is high. It does not pulse otherwise.
- R11: A `load_i` strobe places the seven load bytes on the visible outputs in the next cycle. It also loads the counters with those bytes, decoded in the current binary/BCD and 12/24-hour format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| osc_sel_i | input | 3 | Oscillator select field; 3'b010 means running |
| set_mode_i | input | 1 | Freeze visible bytes, suppress update indication |
| bin_mode_i | input | 1 | 1 = binary, 0 = BCD |
| h24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarm_en_i | input | 1 | Alarm pulse enable |
| upd_en_i | input | 1 | Update-ended pulse enable |
| alarm_sec_i | input | 8 | Seconds alarm byte |
| alarm_min_i | input | 8 | Minutes alarm byte |
| alarm_hr_i | input | 8 | Hours alarm byte |
| load_i | input | 1 | Load strobe for the time bytes |
| ld_sec_i | input | 8 | Seconds byte to load |
| ld_min_i | input | 8 | Minutes byte to load |
| ld_hr_i | input | 8 | Hours byte to load |
| ld_dow_i | input | 8 | Day-of-week byte to load |
| ld_date_i | input | 8 | Day-of-month byte to load |
| ld_mon_i | input | 8 | Month byte to load |
| ld_yr_i | input | 8 | Year byte to load |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hr_o | output | 8 | Visible hours |
| dow_o | output | 8 | Visible day of week |
| date_o | output | 8 | Visible day of month |
| mon_o | output | 8 | Visible month |
| yr_o | output | 8 | Visible year |
| uip_o | output | 1 | Update in progress |
| alarm_o | output | 1 | Alarm match pulse |
| upd_done_o | output | 1 | Update-ended pulse |

## Verification
A counter that carries wrongly shows up only `UPD_CYCLES` cycles after the tick, when the visible bytes refresh. Many such faults also stay hidden until the boundary they break is reached, such as the end of a month, a leap February, noon or a year wrap. The stimulus therefore loads the clock to one second before each boundary and compares every byte on the update-ended pulse. A corrupted window counter appears at once in the length of `uip_o`, which is measured on every tick. A set-mode or oscillator gate that leaks shows up as an unexpected pulse, or as a second that has been lost or added on the first normal update afterwards.

// File: rtl/rtc_tod_pkg.sv
package rtc_tod_pkg;

  typedef struct packed {
    logic [6:0] yr;
    logic [6:0] mon;
    logic [6:0] date;
    logic [6:0] dow;
    logic [6:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } tod_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } tod_bytes_t;

  localparam logic [2:0] OSC_RUN = 3'b010;
  localparam tod_t TOD_RST = '{yr: 7'd0, mon: 7'd1, date: 7'd1, dow: 7'd1,
                               hr: 7'd0, min: 7'd0, sec: 7'd0};
  localparam tod_bytes_t VIS_RST = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                     hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : ({3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]});
  endfunction

  // year divisible by 4 -> leap
  function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import rtc_tod_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic load_i,
  input  tod_t load_val_i,
  output tod_t tod_o
);

  tod_t q, nxt;

  always_comb begin
    nxt = q;
    if (q.sec < 7'd59) nxt.sec = q.sec + 7'd1;
    else begin
      nxt.sec = 7'd0;
      if (q.min < 7'd59) nxt.min = q.min + 7'd1;
      else begin
        nxt.min = 7'd0;
        if (q.hr < 7'd23) nxt.hr = q.hr + 7'd1;
        else begin
          nxt.hr  = 7'd0;
          nxt.dow = (q.dow >= 7'd7) ? 7'd1 : q.dow + 7'd1;
          if (q.date < month_days(q.mon, q.yr)) nxt.date = q.date + 7'd1;
          else begin
            nxt.date = 7'd1;
            if (q.mon < 7'd12) nxt.mon = q.mon + 7'd1;
            else begin
              nxt.mon = 7'd1;
              nxt.yr  = (q.yr >= 7'd99) ? 7'd0 : q.yr + 7'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= TOD_RST;
    else if (load_i) q <= load_val_i;
    else if (adv_i)  q <= nxt;
  end

  assign tod_o = q;

  a_r2_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && q.sec == 7'd59) |=> (q.sec == 7'd0 && q.min != $past(q.min)));

endmodule

// File: rtl/tod_encode.sv
module tod_encode
  import rtc_tod_pkg::*;
(
  input  tod_t       tod_i,
  input  logic       bin_i,
  input  logic       h24_i,
  output tod_bytes_t bytes_o
);

  logic       pm;
  logic [6:0] h12;
  logic [7:0] h12_b;

  always_comb begin
    pm  = tod_i.hr >= 7'd12;
    h12 = pm ? tod_i.hr - 7'd12 : tod_i.hr;
    if (h12 == 7'd0) h12 = 7'd12;
    h12_b = enc_val(h12, bin_i);
    bytes_o.sec  = enc_val(tod_i.sec,  bin_i);
    bytes_o.min  = enc_val(tod_i.min,  bin_i);
    bytes_o.hr   = h24_i ? enc_val(tod_i.hr, bin_i) : {pm, h12_b[6:0]};
    bytes_o.dow  = enc_val(tod_i.dow,  bin_i);
    bytes_o.date = enc_val(tod_i.date, bin_i);
    bytes_o.mon  = enc_val(tod_i.mon,  bin_i);
    bytes_o.yr   = enc_val(tod_i.yr,   bin_i);
  end

endmodule

// File: rtl/tod_decode.sv
module tod_decode
  import rtc_tod_pkg::*;
(
  input  tod_bytes_t bytes_i,
  input  logic       bin_i,
  input  logic       h24_i,
  output tod_t       tod_o
);

  logic [6:0] h_raw, h_base;

  always_comb begin
    h_raw  = dec_val({1'b0, bytes_i.hr[6:0]}, bin_i);
    h_base = (h_raw == 7'd12) ? 7'd0 : h_raw;
    tod_o.sec  = dec_val(bytes_i.sec,  bin_i);
    tod_o.min  = dec_val(bytes_i.min,  bin_i);
    tod_o.hr   = h24_i ? dec_val(bytes_i.hr, bin_i)
                       : (bytes_i.hr[7] ? h_base + 7'd12 : h_base);
    tod_o.dow  = dec_val(bytes_i.dow,  bin_i);
    tod_o.date = dec_val(bytes_i.date, bin_i);
    tod_o.mon  = dec_val(bytes_i.mon,  bin_i);
    tod_o.yr   = dec_val(bytes_i.yr,   bin_i);
  end

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
  parameter int NFIELD = 3
) (
  input  logic [NFIELD-1:0][7:0] now_i,
  input  logic [NFIELD-1:0][7:0] alm_i,
  output logic                   match_o
);

  logic [NFIELD-1:0] hit;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    assign hit[i] = (alm_i[i][7:6] == 2'b11) || (alm_i[i] == now_i[i]);
  end

  assign match_o = &hit;

endmodule

// File: rtl/rtc_tod_engine.sv
module rtc_tod_engine
  import rtc_tod_pkg::*;
#(
  parameter int UPD_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] osc_sel_i,
  input  logic       set_mode_i,
  input  logic       bin_mode_i,
  input  logic       h24_i,
  input  logic       alarm_en_i,
  input  logic       upd_en_i,
  input  logic [7:0] alarm_sec_i,
  input  logic [7:0] alarm_min_i,
  input  logic [7:0] alarm_hr_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hr_i,
  input  logic [7:0] ld_dow_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_yr_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o,
  output logic       uip_o,
  output logic       alarm_o,
  output logic       upd_done_o
);

  localparam int CW = $clog2(UPD_CYCLES + 1);

  tod_t       cur, ld_val;
  tod_bytes_t ld_b, enc_b, vis_q;
  logic       accept, finish, match;
  logic       busy_q, uip_q, alarm_q, upd_q;
  logic [CW-1:0] cnt_q;

  assign ld_b   = {ld_yr_i, ld_mon_i, ld_date_i, ld_dow_i, ld_hr_i, ld_min_i, ld_sec_i};
  // ticks arriving inside an update window are dropped
  assign accept = tick_i && (osc_sel_i == OSC_RUN) && !busy_q && !load_i;
  assign finish = busy_q && (cnt_q == '0);

  tod_decode u_dec (.bytes_i(ld_b), .bin_i(bin_mode_i), .h24_i(h24_i), .tod_o(ld_val));

  tod_counter u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(accept), .load_i(load_i),
    .load_val_i(ld_val), .tod_o(cur)
  );

  tod_encode u_enc (.tod_i(cur), .bin_i(bin_mode_i), .h24_i(h24_i), .bytes_o(enc_b));

  tod_alarm #(.NFIELD(3)) u_alm (
    .now_i({enc_b.hr, enc_b.min, enc_b.sec}),
    .alm_i({alarm_hr_i, alarm_min_i, alarm_sec_i}),
    .match_o(match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(UPD_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uip_q   <= 1'b0;
      vis_q   <= VIS_RST;
      alarm_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      if (set_mode_i)  uip_q <= 1'b0;
      else if (accept) uip_q <= 1'b1;
      else if (finish) uip_q <= 1'b0;
      if (load_i)                     vis_q <= ld_b;
      else if (finish && !set_mode_i) vis_q <= enc_b;
      alarm_q <= finish && alarm_en_i && match;
      upd_q   <= finish && upd_en_i;
    end
  end

  assign sec_o      = vis_q.sec;
  assign min_o      = vis_q.min;
  assign hr_o       = vis_q.hr;
  assign dow_o      = vis_q.dow;
  assign date_o     = vis_q.date;
  assign mon_o      = vis_q.mon;
  assign yr_o       = vis_q.yr;
  assign uip_o      = uip_q;
  assign alarm_o    = alarm_q;
  assign upd_done_o = upd_q;

  a_r8_set_no_uip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mode_i |=> !uip_o);
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mode_i && !load_i) |=> ($stable(sec_o) && $stable(hr_o) && $stable(date_o)));
  a_r6_osc_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && osc_sel_i != OSC_RUN && !busy_q && !load_i) |=> !busy_q);
  a_r7_uip_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && osc_sel_i == OSC_RUN && !busy_q && !load_i && !set_mode_i) |=> uip_o);
  a_r10_upd_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |-> $fell(busy_q));
  a_r9_alarm_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> ($past(alarm_en_i) && $fell(busy_q)));

endmodule

// File: tb/sim_rtc_tod_engine.sv
`timescale 1ns/1ps
module sim_rtc_tod_engine;

  localparam int UPD = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, set_mode_i = 1'b0, bin_mode_i = 1'b0, h24_i = 1'b1;
  logic alarm_en_i = 1'b1, upd_en_i = 1'b1, load_i = 1'b0;
  logic [2:0] osc_sel_i = 3'b010;
  logic [7:0] alarm_sec_i = 8'h77, alarm_min_i = 8'h77, alarm_hr_i = 8'h77;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hr_i = '0, ld_dow_i = '0;
  logic [7:0] ld_date_i = '0, ld_mon_i = '0, ld_yr_i = '0;
  logic [7:0] sec_o, min_o, hr_o, dow_o, date_o, mon_o, yr_o;
  logic uip_o, alarm_o, upd_done_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [56:0] exp_q[$];
  string tag_q[$];

  always #10 clk_i = ~clk_i;

  rtc_tod_engine #(.UPD_CYCLES(UPD)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] s, mi, h, dw, dt, mo, y, input logic alm, input string tag);
    exp_q.push_back({alm, y, mo, dt, dw, h, mi, s});
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: one item per update-ended pulse
  always @(negedge clk_i) begin
    if (rst_ni && upd_done_o) begin
      logic [56:0] act;
      act = {alarm_o, yr_o, mon_o, date_o, dow_o, hr_o, min_o, sec_o};
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected pulse", 64'(act), 64'h0);
      else begin
        logic [56:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act == e, t, 64'(act), 64'(e));
      end
    end
  end

  task automatic do_tick(input int exp_uip, input string tag);
    int n = 0;
    @(posedge clk_i); #1 tick_i = 1'b1;
    @(posedge clk_i); #1 tick_i = 1'b0;
    repeat (UPD + 2) begin
      @(negedge clk_i);
      if (uip_o) n++;
    end
    chk(n == exp_uip, tag, 64'(n), 64'(exp_uip));
  endtask

  task automatic load(input logic [7:0] s, mi, h, dw, dt, mo, y);
    @(posedge clk_i); #1;
    {ld_sec_i, ld_min_i, ld_hr_i, ld_dow_i, ld_date_i, ld_mon_i, ld_yr_i} = {s, mi, h, dw, dt, mo, y};
    load_i = 1'b1;
    @(posedge clk_i); #1 load_i = 1'b0;
    chk({sec_o, hr_o, date_o} == {s, h, dt}, "R11 load visible", 64'({sec_o, hr_o, date_o}), 64'({s, h, dt}));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk({yr_o, mon_o, date_o, dow_o, hr_o, min_o, sec_o} == 56'h00_01_01_01_00_00_00,
        "R1 reset bytes", 64'({yr_o, mon_o, date_o, dow_o, hr_o, min_o, sec_o}), 64'h00010101000000);
    chk({uip_o, alarm_o, upd_done_o} == 3'b000, "R1 reset flags", 64'({uip_o, alarm_o, upd_done_o}), 64'h0);

    // R11 + R2 + R3: BCD 24h, non-leap February end, day-of-week 7 -> 1
    load(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    push(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23, 0, "R11 decode then advance");
    do_tick(UPD, "R7 uip length");
    push(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23, 0, "R2 R3 carry Feb28 nonleap");
    do_tick(UPD, "R7 uip length");
    // R3 leap year
    load(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    push(8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24, 0, "R3 leap Feb29");
    do_tick(UPD, "R7 uip length");
    load(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    push(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h24, 0, "R3 leap Feb29 end");
    do_tick(UPD, "R7 uip length");
    load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h24);
    push(8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h24, 0, "R3 30-day month");
    do_tick(UPD, "R7 uip length");

    // R4 binary mode: year wrap and 9 -> 10
    bin_mode_i = 1'b1;
    load(8'h3B, 8'h3B, 8'h17, 8'h07, 8'h1F, 8'h0C, 8'h63);
    push(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 0, "R4 R3 binary year wrap");
    do_tick(UPD, "R7 uip length");
    load(8'h09, 8'h05, 8'h0A, 8'h02, 8'h0F, 8'h06, 8'h10);
    push(8'h0A, 8'h05, 8'h0A, 8'h02, 8'h0F, 8'h06, 8'h10, 0, "R4 binary 9->10");
    do_tick(UPD, "R7 uip length");
    bin_mode_i = 1'b0;
    load(8'h09, 8'h05, 8'h10, 8'h02, 8'h15, 8'h06, 8'h10);
    push(8'h10, 8'h05, 8'h10, 8'h02, 8'h15, 8'h06, 8'h10, 0, "R4 BCD 9->10");
    do_tick(UPD, "R7 uip length");

    // R5 12-hour mode
    h24_i = 1'b0;
    load(8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h05, 8'h24);
    push(8'h00, 8'h00, 8'h92, 8'h01, 8'h10, 8'h05, 8'h24, 0, "R5 11AM->12PM");
    do_tick(UPD, "R7 uip length");
    load(8'h59, 8'h59, 8'h92, 8'h01, 8'h10, 8'h05, 8'h24);
    push(8'h00, 8'h00, 8'h81, 8'h01, 8'h10, 8'h05, 8'h24, 0, "R5 12PM->1PM");
    do_tick(UPD, "R7 uip length");
    load(8'h59, 8'h59, 8'h91, 8'h01, 8'h10, 8'h05, 8'h24);
    push(8'h00, 8'h00, 8'h12, 8'h02, 8'h11, 8'h05, 8'h24, 0, "R5 11PM->12AM");
    do_tick(UPD, "R7 uip length");
    h24_i = 1'b1;

    // R9 alarm
    load(8'h29, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24);
    {alarm_sec_i, alarm_min_i, alarm_hr_i} = {8'hC0, 8'h30, 8'h08};
    push(8'h30, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 1, "R9 wildcard sec");
    do_tick(UPD, "R7 uip length");
    alarm_sec_i = 8'h31;
    push(8'h31, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 1, "R9 exact match");
    do_tick(UPD, "R7 uip length");
    {alarm_sec_i, alarm_hr_i} = {8'hC0, 8'h09};
    push(8'h32, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 0, "R9 hour mismatch");
    do_tick(UPD, "R7 uip length");
    {alarm_sec_i, alarm_min_i, alarm_hr_i} = {8'hC0, 8'hFF, 8'hC1};
    push(8'h33, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 1, "R9 all wildcard");
    do_tick(UPD, "R7 uip length");
    alarm_en_i = 1'b0;
    push(8'h34, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 0, "R9 alarm disabled");
    do_tick(UPD, "R7 uip length");
    alarm_en_i = 1'b1;
    {alarm_sec_i, alarm_min_i, alarm_hr_i} = {8'h77, 8'h77, 8'h77};

    // R8 set mode: frozen, no uip, counting continues
    set_mode_i = 1'b1;
    push(8'h34, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 0, "R8 frozen");
    do_tick(0, "R8 no uip");
    push(8'h34, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 0, "R8 frozen");
    do_tick(0, "R8 no uip");
    set_mode_i = 1'b0;
    push(8'h37, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 0, "R8 counted through set");
    do_tick(UPD, "R7 uip length");

    // R6 oscillator gate
    osc_sel_i = 3'b000;
    do_tick(0, "R6 no uip osc 000");
    osc_sel_i = 3'b110;
    do_tick(0, "R6 no uip osc 110");
    chk(sec_o == 8'h37, "R6 time held", 64'(sec_o), 64'h37);
    osc_sel_i = 3'b010;
    push(8'h38, 8'h30, 8'h08, 8'h03, 8'h15, 8'h06, 8'h24, 0, "R6 no lost or extra second");
    do_tick(UPD, "R7 uip length");

    // R10 update-ended pulse suppressed when disabled
    upd_en_i = 1'b0;
    do_tick(UPD, "R7 uip length");
    chk(sec_o == 8'h39, "R10 update without pulse", 64'(sec_o), 64'h39);
    upd_en_i = 1'b1;
    repeat (4) @(posedge clk_i);
    chk(exp_q.size() == 0, "R10 missing pulses", 64'(exp_q.size()), 64'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule